// File: doc/BRIEF.md
# Locality-aware thread block dispatcher

This block hands thread blocks to a small array of streaming multiprocessor (SM) cores. A launcher presents one block descriptor per cycle: a block id, a flag marking it as a child launched from a running block, the SM on which that parent block ran, and a priority. Accepted descriptors wait in one queue per SM. Each queue is served in priority order, with arrival order breaking ties. Every cycle the block may issue one waiting block to an SM that still has a free execution slot.

A two-bit policy input selects one of four policies. The baseline spreads launches over the SMs in turn and serves each queue in arrival order. The prioritizing policy serves children, which carry their parent's priority plus one, ahead of older parent blocks. The binding policy also queues each child on its parent's SM so that the child can reuse that SM's cache. The adaptive policy keeps binding but lets an idle SM take a child that is waiting behind an SM with no free slots.

The block keeps one free-slot count per SM. An issue to an SM decrements its count, and a completion pulse from that SM increments it. When the queue chosen for a launch is full, the launch interface stalls.

Top module: `tblk_disp`

## Requirements
- R1: During and right after reset, no block is issued (`dsp_valid` low), `lnch_rdy` is high, every queue is empty, every SM has MAX_SLOTS free slots and the turn pointer is at SM 0.
- R2: With `mode` = 0, every accepted launch goes to the queue of the SM named by the turn pointer, which then advances by one and wraps after the last SM. Each queue is served strictly in arrival order and priority is ignored.
- R3: With `mode` = 1, a launch with `lnch_child` = 1 is stored with priority `lnch_prio`+1, held at the maximum value when it would overflow. A launch with `lnch_child` = 0 is stored with `lnch_prio`. Within a queue the entry with the largest stored priority is served first, and among equal priorities the earliest arrival is served first. Placement follows the turn pointer as in R2.
- R4: With `mode` = 2 or 3, a child launch is queued on the SM given by `lnch_sm`, and a parent launch is queued on the SM named by the turn pointer. Priority ordering follows R3.
- R5: With `mode` = 3, when no SM can issue from its own queue, the lowest-numbered SM with a free slot and an empty queue takes the block selected in the lowest-numbered queue whose SM has zero free slots, provided that block is a child. `dsp_sm` names the SM that takes it.
- R6: At most one block is issued per cycle. The issuing SM is the lowest-numbered SM with a non-empty queue and a free slot, and such an issue always wins over an adaptive take.
- R7: An issue to an SM lowers its free-slot count by one, and a `sm_done` pulse raises it by one. A pulse that would lift the count above MAX_SLOTS is ignored. No block is ever issued to an SM whose count is zero.
- R8: `lnch_rdy` is low exactly when the queue chosen for the present launch already holds Q_DEPTH entries. A launch offered while `lnch_rdy` is low is not stored.
- R9: With `mode` = 2 or 3, only accepted parent launches advance the turn pointer. Child launches leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Policy: 0 turn-based, 1 prioritize, 2 prioritize and bind, 3 adaptive bind |
| lnch_valid | input | 1 | A block descriptor is offered |
| lnch_rdy | output | 1 | The target queue has room; the descriptor is taken when both are high |
| lnch_id | input | ID_W | Block identifier |
| lnch_child | input | 1 | 1 if the block was launched by a running parent block |
| lnch_sm | input | log2(NUM_SM) | SM that ran the parent block (used for children) |
| lnch_prio | input | PRIO_W | Priority of the block, or of its parent for a child |
| sm_done | input | NUM_SM | One completion pulse per SM, frees one slot |
| dsp_valid | output | 1 | A block is issued this cycle |
| dsp_sm | output | log2(NUM_SM) | SM that receives the issued block |
| dsp_id | output | ID_W | Identifier of the issued block |
| dsp_child | output | 1 | Child flag of the issued block |

## Verification
The assertions watch the slot bookkeeping on every cycle. They check that no count leaves the range 0 to MAX_SLOTS, that an issue or a completion moves the count by exactly one, that no block is issued to an SM with zero free slots, that no queue grows past its depth, and that outside the adaptive policy every issue comes from the issuing SM's own queue. Which block is chosen, where a launch is placed, how the turn pointer moves, and when an idle SM takes a child from a busy one can only be shown by the bench's scenarios. The bench runs each policy under heavy and light load against a queue-based reference model.

// File: rtl/tblk_pkg.sv
package tblk_pkg;
    localparam int ID_W   = 8;
    localparam int PRIO_W = 3;

    typedef struct packed {
        logic [ID_W-1:0]   id;
        logic [PRIO_W-1:0] prio;
        logic              child;
    } ent_t;

    localparam logic [1:0] MODE_RR    = 2'd0;
    localparam logic [1:0] MODE_PRI   = 2'd1;
    localparam logic [1:0] MODE_BIND  = 2'd2;
    localparam logic [1:0] MODE_ADAPT = 2'd3;
endpackage

// File: rtl/tblk_pick.sv
// Selects the entry to serve from one queue: the largest priority, the
// earliest arrival among equals (entries are kept in arrival order).
module tblk_pick #(
    parameter int DEPTH  = 4,
    parameter int PRIO_W = 3,
    localparam int CNT_W = $clog2(DEPTH + 1),
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0][PRIO_W-1:0] prio,
    input  logic [DEPTH-1:0]             child,
    input  logic [CNT_W-1:0]             cnt,
    input  logic                         use_prio,
    output logic [IDX_W-1:0]             idx,
    output logic                         is_child
);
    always_comb begin
        idx = '0;
        for (int i = 1; i < DEPTH; i++) begin
            if (use_prio && (CNT_W'(i) < cnt) && (prio[i] > prio[idx])) begin
                idx = IDX_W'(i);
            end
        end
        is_child = child[idx];
    end
endmodule

// File: rtl/tblk_lowest.sv
// Lowest-index request finder.
module tblk_lowest #(
    parameter int N = 4,
    localparam int W = $clog2(N)
) (
    input  logic [N-1:0] req,
    output logic         any,
    output logic [W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = W'(i);
        end
    end
endmodule

// File: rtl/tblk_disp.sv
module tblk_disp
    import tblk_pkg::*;
#(
    parameter int NUM_SM    = 4,
    parameter int Q_DEPTH   = 4,
    parameter int MAX_SLOTS = 2,
    localparam int SM_W   = $clog2(NUM_SM),
    localparam int CNT_W  = $clog2(Q_DEPTH + 1),
    localparam int IDX_W  = $clog2(Q_DEPTH),
    localparam int FREE_W = $clog2(MAX_SLOTS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              lnch_valid,
    output logic              lnch_rdy,
    input  logic [ID_W-1:0]   lnch_id,
    input  logic              lnch_child,
    input  logic [SM_W-1:0]   lnch_sm,
    input  logic [PRIO_W-1:0] lnch_prio,
    input  logic [NUM_SM-1:0] sm_done,
    output logic              dsp_valid,
    output logic [SM_W-1:0]   dsp_sm,
    output logic [ID_W-1:0]   dsp_id,
    output logic              dsp_child
);
    typedef struct packed {
        ent_t [NUM_SM-1:0][Q_DEPTH-1:0] q;
        logic [NUM_SM-1:0][CNT_W-1:0]   cnt;
        logic [NUM_SM-1:0][FREE_W-1:0]  free;
        logic [SM_W-1:0]                rr;
    } st_t;

    st_t s_d, s_q;

    logic [NUM_SM-1:0][IDX_W-1:0] pk_idx;
    logic [NUM_SM-1:0]            pk_child;
    logic [NUM_SM-1:0]            loc_req, thief_req, vic_req;
    logic                         loc_any, thief_any, vic_any;
    logic [SM_W-1:0]              loc_idx, thief_idx, vic_idx;
    logic [SM_W-1:0]              src, tgt;
    logic                         use_prio, bind_on;
    ent_t                         new_ent;

    assign use_prio = (mode != MODE_RR);
    assign bind_on  = mode[1];

    for (genvar g = 0; g < NUM_SM; g++) begin : g_sm
        logic [Q_DEPTH-1:0][PRIO_W-1:0] pr;
        logic [Q_DEPTH-1:0]             ch;
        for (genvar e = 0; e < Q_DEPTH; e++) begin : g_ent
            assign pr[e] = s_q.q[g][e].prio;
            assign ch[e] = s_q.q[g][e].child;
        end
        tblk_pick #(.DEPTH(Q_DEPTH), .PRIO_W(PRIO_W)) u_pick (
            .prio(pr), .child(ch), .cnt(s_q.cnt[g]), .use_prio(use_prio),
            .idx(pk_idx[g]), .is_child(pk_child[g])
        );
        assign loc_req[g]   = (s_q.cnt[g] != '0) && (s_q.free[g] != '0);
        assign thief_req[g] = (s_q.cnt[g] == '0) && (s_q.free[g] != '0);
        assign vic_req[g]   = (s_q.cnt[g] != '0) && (s_q.free[g] == '0) && pk_child[g];
    end

    tblk_lowest #(.N(NUM_SM)) u_loc   (.req(loc_req),   .any(loc_any),   .idx(loc_idx));
    tblk_lowest #(.N(NUM_SM)) u_thief (.req(thief_req), .any(thief_any), .idx(thief_idx));
    tblk_lowest #(.N(NUM_SM)) u_vic   (.req(vic_req),   .any(vic_any),   .idx(vic_idx));

    always_comb begin
        s_d       = s_q;
        dsp_valid = 1'b0;
        dsp_sm    = '0;
        src       = '0;

        // issue selection: own queue first, adaptive take second
        if (loc_any) begin
            dsp_valid = 1'b1;
            dsp_sm    = loc_idx;
            src       = loc_idx;
        end else if ((mode == MODE_ADAPT) && thief_any && vic_any) begin
            dsp_valid = 1'b1;
            dsp_sm    = thief_idx;
            src       = vic_idx;
        end
        dsp_id    = s_q.q[src][pk_idx[src]].id;
        dsp_child = s_q.q[src][pk_idx[src]].child;

        if (dsp_valid) begin
            for (int i = 0; i < Q_DEPTH - 1; i++) begin
                if (IDX_W'(i) >= pk_idx[src]) s_d.q[src][i] = s_q.q[src][i+1];
            end
            s_d.cnt[src]     = s_q.cnt[src] - CNT_W'(1);
            s_d.free[dsp_sm] = s_q.free[dsp_sm] - FREE_W'(1);
        end

        for (int s = 0; s < NUM_SM; s++) begin
            if (sm_done[s] && (s_d.free[s] < FREE_W'(MAX_SLOTS))) begin
                s_d.free[s] = s_d.free[s] + FREE_W'(1);
            end
        end

        // launch placement
        tgt      = (bind_on && lnch_child) ? lnch_sm : s_q.rr;
        lnch_rdy = (s_q.cnt[tgt] < CNT_W'(Q_DEPTH));
        new_ent.id    = lnch_id;
        new_ent.child = lnch_child;
        new_ent.prio  = (lnch_child && (lnch_prio != '1)) ? lnch_prio + PRIO_W'(1) : lnch_prio;
        if (lnch_valid && lnch_rdy) begin
            for (int i = 0; i < Q_DEPTH; i++) begin
                if (CNT_W'(i) == s_d.cnt[tgt]) s_d.q[tgt][i] = new_ent;
            end
            s_d.cnt[tgt] = s_d.cnt[tgt] + CNT_W'(1);
            if (!(bind_on && lnch_child)) begin
                s_d.rr = (s_q.rr == SM_W'(NUM_SM - 1)) ? '0 : s_q.rr + SM_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
            for (int s = 0; s < NUM_SM; s++) begin
                s_q.free[s] <= FREE_W'(MAX_SLOTS);
            end
        end else begin
            s_q <= s_d;
        end
    end
endmodule

// File: rtl/tblk_disp_chk.sv
module tblk_disp_chk #(
    parameter int NUM_SM    = 4,
    parameter int Q_DEPTH   = 4,
    parameter int MAX_SLOTS = 2,
    localparam int SM_W   = $clog2(NUM_SM),
    localparam int CNT_W  = $clog2(Q_DEPTH + 1),
    localparam int FREE_W = $clog2(MAX_SLOTS + 1)
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [1:0]                    mode,
    input logic                          dsp_valid,
    input logic [SM_W-1:0]               dsp_sm,
    input logic [NUM_SM-1:0]             sm_done,
    input logic [NUM_SM-1:0][FREE_W-1:0] free_vec,
    input logic [NUM_SM-1:0][CNT_W-1:0]  cnt_vec
);
    assert_no_issue_to_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_valid |-> (free_vec[dsp_sm] != '0));

    assert_issue_from_own_queue_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dsp_valid && (mode != 2'd3)) |-> (cnt_vec[dsp_sm] != '0));

    for (genvar g = 0; g < NUM_SM; g++) begin : g_chk
        assert_slot_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
            free_vec[g] <= FREE_W'(MAX_SLOTS));

        assert_queue_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
            cnt_vec[g] <= CNT_W'(Q_DEPTH));

        assert_issue_takes_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (dsp_valid && (dsp_sm == SM_W'(g)) && !sm_done[g])
            |=> (free_vec[g] == $past(free_vec[g]) - FREE_W'(1)));

        assert_done_gives_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (!(dsp_valid && (dsp_sm == SM_W'(g))) && sm_done[g] && (free_vec[g] < FREE_W'(MAX_SLOTS)))
            |=> (free_vec[g] == $past(free_vec[g]) + FREE_W'(1)));
    end
endmodule

bind tblk_disp tblk_disp_chk #(
    .NUM_SM(NUM_SM), .Q_DEPTH(Q_DEPTH), .MAX_SLOTS(MAX_SLOTS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .mode(mode), .dsp_valid(dsp_valid), .dsp_sm(dsp_sm),
    .sm_done(sm_done), .free_vec(s_q.free), .cnt_vec(s_q.cnt)
);

// File: tb/tblk_disp_bench.sv
module tblk_disp_bench;
    import tblk_pkg::*;

    localparam int NSM = 4;
    localparam int QD  = 4;
    localparam int MS  = 2;
    localparam int PMAX = (1 << PRIO_W) - 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mode = 2'd0;
    logic              lnch_valid = 1'b0;
    logic              lnch_rdy;
    logic [ID_W-1:0]   lnch_id = '0;
    logic              lnch_child = 1'b0;
    logic [1:0]        lnch_sm = '0;
    logic [PRIO_W-1:0] lnch_prio = '0;
    logic [NSM-1:0]    sm_done = '0;
    logic              dsp_valid;
    logic [1:0]        dsp_sm;
    logic [ID_W-1:0]   dsp_id;
    logic              dsp_child;

    always #10 clk = ~clk;   // 50 MHz

    tblk_disp #(.NUM_SM(NSM), .Q_DEPTH(QD), .MAX_SLOTS(MS)) u_tblk_disp (
        .clk(clk), .rst_n(rst_n), .mode(mode), .lnch_valid(lnch_valid), .lnch_rdy(lnch_rdy),
        .lnch_id(lnch_id), .lnch_child(lnch_child), .lnch_sm(lnch_sm), .lnch_prio(lnch_prio),
        .sm_done(sm_done), .dsp_valid(dsp_valid), .dsp_sm(dsp_sm), .dsp_id(dsp_id),
        .dsp_child(dsp_child)
    );

    typedef struct {
        int id;
        int prio;
        bit child;
    } m_ent_t;

    m_ent_t mq[NSM][$];
    int     mfree[NSM];
    int     mrr;
    int     n_run = 0;
    int     n_fail = 0;
    bit     done_flag = 0;

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int mpick(int s, int md);
        int best = 0;
        for (int i = 1; i < mq[s].size(); i++) begin
            if (md != 0 && mq[s][i].prio > mq[s][best].prio) best = i;
        end
        return best;
    endfunction

    task automatic model_reset();
        for (int s = 0; s < NSM; s++) begin
            mq[s].delete();
            mfree[s] = MS;
        end
        mrr = 0;
    endtask

    // Compare outputs against the model, then advance the model by one cycle.
    task automatic model_cycle(int md);
        bit    e_v = 0;
        int    e_sm = 0, e_src = 0, pi = 0, tgt;
        bit    e_rdy;
        string tag;
        m_ent_t ne;
        case (md)
            0: tag = "R2 R6 R7";
            1: tag = "R3 R6 R7";
            2: tag = "R4 R9 R6 R7";
            default: tag = "R5 R4 R9 R6 R7";
        endcase
        for (int s = NSM - 1; s >= 0; s--) begin
            if (mq[s].size() > 0 && mfree[s] > 0) begin
                e_v = 1; e_sm = s; e_src = s;
            end
        end
        if (!e_v && md == 3) begin
            int th = -1, vi = -1;
            for (int s = NSM - 1; s >= 0; s--) begin
                if (mq[s].size() == 0 && mfree[s] > 0) th = s;
                if (mq[s].size() > 0 && mfree[s] == 0 && mq[s][mpick(s, md)].child) vi = s;
            end
            if (th >= 0 && vi >= 0) begin
                e_v = 1; e_sm = th; e_src = vi;
            end
        end
        check(dsp_valid == e_v, tag, "dsp_valid", int'(dsp_valid), int'(e_v));
        if (e_v && dsp_valid) begin
            pi = mpick(e_src, md);
            check(int'(dsp_sm) == e_sm, tag, "dsp_sm", int'(dsp_sm), e_sm);
            check(int'(dsp_id) == mq[e_src][pi].id, tag, "dsp_id", int'(dsp_id), mq[e_src][pi].id);
            check(dsp_child == mq[e_src][pi].child, tag, "dsp_child",
                  int'(dsp_child), int'(mq[e_src][pi].child));
        end
        tgt   = (md >= 2 && lnch_child) ? int'(lnch_sm) : mrr;
        e_rdy = mq[tgt].size() < QD;
        check(lnch_rdy == e_rdy, "R8", "lnch_rdy", int'(lnch_rdy), int'(e_rdy));

        if (e_v) begin
            mq[e_src].delete(pi);
            mfree[e_sm]--;
        end
        for (int s = 0; s < NSM; s++) begin
            if (sm_done[s] && mfree[s] < MS) mfree[s]++;
        end
        if (lnch_valid && e_rdy) begin
            ne.id    = int'(lnch_id);
            ne.child = lnch_child;
            ne.prio  = lnch_child ? ((int'(lnch_prio) == PMAX) ? PMAX : int'(lnch_prio) + 1)
                                  : int'(lnch_prio);
            mq[tgt].push_back(ne);
            if (!(md >= 2 && lnch_child)) mrr = (mrr + 1) % NSM;
        end
    endtask

    task automatic do_reset(int md);
        @(negedge clk);
        rst_n = 1'b0;
        mode = 2'(md);
        lnch_valid = 1'b0;
        sm_done = '0;
        model_reset();
        @(negedge clk);
        @(negedge clk);
        #1;
        check(dsp_valid == 1'b0, "R1", "dsp_valid in reset", int'(dsp_valid), 0);
        check(lnch_rdy == 1'b1, "R1", "lnch_rdy in reset", int'(lnch_rdy), 1);
        rst_n = 1'b1;
    endtask

    task automatic run_phase(int md, int cycles, int lpct, int dpct);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            lnch_valid = (($urandom % 100) < lpct);
            lnch_id    = lnch_id + 8'd1;
            lnch_child = (($urandom % 2) == 1);
            lnch_sm    = (($urandom % 4) == 0) ? 2'($urandom % NSM) : 2'd0;
            lnch_prio  = PRIO_W'($urandom % (PMAX + 1));
            for (int s = 0; s < NSM; s++) sm_done[s] = (($urandom % 100) < dpct);
            #1;
            model_cycle(md);
        end
    endtask

    initial begin
        for (int md = 0; md < 4; md++) begin
            do_reset(md);
            // first cycle out of reset: queues empty, all slots free (R1)
            @(negedge clk);
            lnch_valid = 1'b0;
            #1;
            check(dsp_valid == 1'b0, "R1", "dsp_valid after reset", int'(dsp_valid), 0);
            model_cycle(md);
            run_phase(md, 300, 70, 10);
            run_phase(md, 300, 30, 30);
            run_phase(md, 100, 0, 40);
        end
        if (!done_flag) begin
            done_flag = 1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done_flag) begin
            done_flag = 1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule